// File: doc/BRIEF.md
# Tape Record Word Transfer Engine

This engine sits between a tape record byte stream and a 16-bit word memory port. A read command packs incoming record bytes into memory words, two at a time. A write command fetches words from memory and sends them out as a byte stream. Two spacing commands count records forward or backward. All four commands use one address register and one count register. Software loads the count as a negative number, so the transfer length is whatever is needed to bring its low field up to the next power of two.

The engine accepts a single command at a time. While a command runs, the engine reports busy. When the command finishes, it gives a one-cycle completion pulse. Every boundary handshake is a plain valid/ready or request/acknowledge pair. For the spacing commands, the record-skipping mechanism is an external agent. That agent acknowledges each record it has passed and says whether a file mark or fault stopped the run.

Top module: `tdma_engine`

## Requirements
- R1: Loading the count register stores bits 14:0 of the load value and copies bit 14 into bit 15.
- R2: Loads of the address and count registers take effect only while the engine is idle and no command starts in the same cycle. In every other case they are dropped.
- R3: A read writes each pair of record bytes to memory as one word, with the first byte in bits 15:8. The first word goes to the address register, and the address advances by one per stored word, wrapping modulo 2^15.
- R4: The requested length in words is 16384 minus count bits 13:0. A zero field therefore requests 16384 words.
- R5: A read record holding more bytes than twice the requested length sets the overflow flag, and only the requested number of words is stored.
- R6: A shorter read record stores (bytes+1)/2 words. An odd byte count sets the odd flag, and the unpaired final byte is stored in bits 15:8 with bits 7:0 zero.
- R7: At the end of a read, the count register advances by the number of words stored, modulo 2^16. During the transfer the count register does not change.
- R8: A write fetches the requested number of words and sends each one as its high byte and then its low byte. It marks the final byte as last. A successful write result then clears the count register.
- R9: A failed write result moves the address register back by the number of words sent and leaves the count register unchanged.
- R10: Space forward (op 2) and space reverse (op 3) add one to the count register on every record acknowledge. They stop when the count reaches zero or an acknowledge carries stop, and then copy the count's low 15 bits into the address register. The direction output is 1 for reverse.
- R11: A command start is ignored while the engine is busy. Completion is a single-cycle done pulse. A memory request is held, with its address steady, until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_addr | input | 1 | Load address register from ld_data |
| ld_cnt | input | 1 | Load count register from ld_data |
| ld_data | input | 15 | Software load value |
| addr_o | output | 15 | Address register |
| cnt_o | output | 16 | Count register |
| cmd_start | input | 1 | Start command |
| cmd_op | input | 2 | 0 read, 1 write, 2 space forward, 3 space reverse |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| odd_flag | output | 1 | Last read record had an odd byte count |
| ovf_flag | output | 1 | Last read record exceeded the requested length |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_addr | output | 15 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| rx_valid | input | 1 | Record byte valid |
| rx_data | input | 8 | Record byte |
| rx_last | input | 1 | Final byte of record |
| rx_ready | output | 1 | Engine accepts a record byte |
| tx_valid | output | 1 | Outgoing byte valid |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final outgoing byte |
| tx_ready | input | 1 | Sink accepts outgoing byte |
| wres_valid | input | 1 | Write result valid |
| wres_fail | input | 1 | Write result is a failure |
| sp_req | output | 1 | Request to pass one record |
| sp_dir | output | 1 | Spacing direction, 1 reverse |
| sp_ack | input | 1 | One record passed |
| sp_stop | input | 1 | File mark or fault, stop spacing |

## Verification
A software register load can arrive in the same clock cycle as a command start. It can also arrive while a read is stalled between two record bytes. The bench provokes the first case by raising ld_addr and cmd_start on the same edge. It provokes the second by loading the address and issuing a write start halfway through a read record. In both cases, the scoreboard's expected memory writes must land at the address that was set before the collision, and no outgoing byte may appear. The final address register is compared against the pre-collision base plus the number of words stored.

// File: rtl/tdma_pkg.sv
package tdma_pkg;

    typedef enum logic [1:0] {
        OP_READ      = 2'd0,
        OP_WRITE     = 2'd1,
        OP_SPACE_FWD = 2'd2,
        OP_SPACE_REV = 2'd3
    } tdma_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_RX,
        ST_RD_MEM,
        ST_RD_FIN,
        ST_WR_FETCH,
        ST_WR_HI,
        ST_WR_LO,
        ST_WR_RES,
        ST_SP_REQ
    } tdma_state_e;

    typedef enum logic [2:0] {
        AU_HOLD,
        AU_LOAD,
        AU_INC,
        AU_REWIND,
        AU_COPY
    } addr_op_e;

endpackage

// File: rtl/tdma_len_calc.sv
// Converts the negative count field into a transfer length in words.
module tdma_len_calc #(
    parameter int FIELD_W = 14
) (
    input  logic [FIELD_W-1:0] cnt_field,
    output logic [FIELD_W:0]   words
);
    localparam logic [FIELD_W:0] FULL = {1'b1, {FIELD_W{1'b0}}};

    always_comb begin
        words = FULL - {1'b0, cnt_field};
    end
endmodule

// File: rtl/tdma_addr_unit.sv
// Next-value selection for the address register.
module tdma_addr_unit
    import tdma_pkg::*;
#(
    parameter int ADDR_W = 15,
    parameter int MW     = 15
) (
    input  addr_op_e           op,
    input  logic [ADDR_W-1:0]  cur,
    input  logic [ADDR_W-1:0]  load_val,
    input  logic [MW-1:0]      back,
    input  logic [ADDR_W-1:0]  copy_val,
    output logic [ADDR_W-1:0]  nxt
);
    always_comb begin
        unique case (op)
            AU_LOAD:   nxt = load_val;
            AU_INC:    nxt = cur + ADDR_W'(1);
            AU_REWIND: nxt = cur - ADDR_W'(back);
            AU_COPY:   nxt = copy_val;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/tdma_engine.sv
module tdma_engine
    import tdma_pkg::*;
#(
    parameter int BYTE_W  = 8,
    parameter int FIELD_W = 14,
    parameter int ADDR_W  = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ld_addr,
    input  logic                 ld_cnt,
    input  logic [FIELD_W:0]     ld_data,
    output logic [ADDR_W-1:0]    addr_o,
    output logic [FIELD_W+1:0]   cnt_o,
    input  logic                 cmd_start,
    input  logic [1:0]           cmd_op,
    output logic                 busy,
    output logic                 done,
    output logic                 odd_flag,
    output logic                 ovf_flag,
    output logic                 mem_req,
    output logic                 mem_we,
    output logic [ADDR_W-1:0]    mem_addr,
    output logic [2*BYTE_W-1:0]  mem_wdata,
    input  logic                 mem_ack,
    input  logic [2*BYTE_W-1:0]  mem_rdata,
    input  logic                 rx_valid,
    input  logic [BYTE_W-1:0]    rx_data,
    input  logic                 rx_last,
    output logic                 rx_ready,
    output logic                 tx_valid,
    output logic [BYTE_W-1:0]    tx_data,
    output logic                 tx_last,
    input  logic                 tx_ready,
    input  logic                 wres_valid,
    input  logic                 wres_fail,
    output logic                 sp_req,
    output logic                 sp_dir,
    input  logic                 sp_ack,
    input  logic                 sp_stop
);
    localparam int CW     = FIELD_W + 2;
    localparam int MW     = FIELD_W + 1;
    localparam int WORD_W = 2 * BYTE_W;

    typedef struct packed {
        tdma_state_e        st;
        logic [CW-1:0]      cnt;
        logic [MW-1:0]      moved;
        logic [BYTE_W-1:0]  hi;
        logic               phase;
        logic               last;
        logic [WORD_W-1:0]  wbuf;
        logic               odd;
        logic               ovf;
        logic               done;
        logic               dir;
    } regs_t;

    regs_t              q, d;
    logic [ADDR_W-1:0]  addr_q, addr_d;
    addr_op_e           addr_op;
    logic [MW-1:0]      limit;
    logic [CW-1:0]      cnt_inc;
    logic               room;

    tdma_len_calc #(.FIELD_W(FIELD_W)) u_len (
        .cnt_field (q.cnt[FIELD_W-1:0]),
        .words     (limit)
    );

    tdma_addr_unit #(.ADDR_W(ADDR_W), .MW(MW)) u_addr (
        .op       (addr_op),
        .cur      (addr_q),
        .load_val (ld_data[ADDR_W-1:0]),
        .back     (q.moved),
        .copy_val (cnt_inc[ADDR_W-1:0]),
        .nxt      (addr_d)
    );

    assign cnt_inc = q.cnt + CW'(1);
    assign room    = (q.moved < limit);

    // Outputs straight from state
    assign addr_o    = addr_q;
    assign cnt_o     = q.cnt;
    assign busy      = (q.st != ST_IDLE);
    assign done      = q.done;
    assign odd_flag  = q.odd;
    assign ovf_flag  = q.ovf;
    assign mem_req   = (q.st == ST_RD_MEM) || (q.st == ST_WR_FETCH);
    assign mem_we    = (q.st == ST_RD_MEM);
    assign mem_addr  = addr_q;
    assign mem_wdata = q.wbuf;
    assign rx_ready  = (q.st == ST_RD_RX);
    assign tx_valid  = (q.st == ST_WR_HI) || (q.st == ST_WR_LO);
    assign tx_data   = (q.st == ST_WR_HI) ? q.wbuf[WORD_W-1:BYTE_W] : q.wbuf[BYTE_W-1:0];
    assign tx_last   = (q.st == ST_WR_LO) && (q.moved == limit);
    assign sp_req    = (q.st == ST_SP_REQ);
    assign sp_dir    = q.dir;

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        addr_op = AU_HOLD;
        unique case (q.st)
            ST_IDLE: begin
                if (cmd_start) begin
                    d.moved = '0;
                    d.phase = 1'b0;
                    d.last  = 1'b0;
                    d.odd   = 1'b0;
                    d.ovf   = 1'b0;
                    d.dir   = (tdma_op_e'(cmd_op) == OP_SPACE_REV);
                    unique case (tdma_op_e'(cmd_op))
                        OP_READ:  d.st = ST_RD_RX;
                        OP_WRITE: d.st = ST_WR_FETCH;
                        default:  d.st = ST_SP_REQ;
                    endcase
                end else begin
                    if (ld_cnt)  d.cnt = {ld_data[FIELD_W], ld_data};
                    if (ld_addr) addr_op = AU_LOAD;
                end
            end
            ST_RD_RX: begin
                if (rx_valid) begin
                    if (!q.phase) begin
                        if (rx_last) begin
                            d.odd = 1'b1;
                            if (room) begin
                                d.wbuf = {rx_data, {BYTE_W{1'b0}}};
                                d.last = 1'b1;
                                d.st   = ST_RD_MEM;
                            end else begin
                                d.ovf = 1'b1;
                                d.st  = ST_RD_FIN;
                            end
                        end else begin
                            d.hi    = rx_data;
                            d.phase = 1'b1;
                        end
                    end else begin
                        d.phase = 1'b0;
                        if (room) begin
                            d.wbuf = {q.hi, rx_data};
                            d.last = rx_last;
                            d.st   = ST_RD_MEM;
                        end else begin
                            d.ovf = 1'b1;
                            if (rx_last) d.st = ST_RD_FIN;
                        end
                    end
                end
            end
            ST_RD_MEM: begin
                if (mem_ack) begin
                    addr_op = AU_INC;
                    d.moved = q.moved + MW'(1);
                    d.st    = q.last ? ST_RD_FIN : ST_RD_RX;
                end
            end
            ST_RD_FIN: begin
                d.cnt  = q.cnt + CW'(q.moved);
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            ST_WR_FETCH: begin
                if (mem_ack) begin
                    addr_op = AU_INC;
                    d.wbuf  = mem_rdata;
                    d.moved = q.moved + MW'(1);
                    d.st    = ST_WR_HI;
                end
            end
            ST_WR_HI: begin
                if (tx_ready) d.st = ST_WR_LO;
            end
            ST_WR_LO: begin
                if (tx_ready) d.st = (q.moved == limit) ? ST_WR_RES : ST_WR_FETCH;
            end
            ST_WR_RES: begin
                if (wres_valid) begin
                    if (wres_fail) addr_op = AU_REWIND;
                    else           d.cnt   = '0;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
            ST_SP_REQ: begin
                if (sp_ack) begin
                    d.cnt = cnt_inc;
                    if (sp_stop || (cnt_inc == '0)) begin
                        addr_op = AU_COPY;
                        d.done  = 1'b1;
                        d.st    = ST_IDLE;
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '{st: ST_IDLE, default: '0};
            addr_q <= '0;
        end else begin
            q      <= d;
            addr_q <= addr_d;
        end
    end

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ack |=> addr_o == $past(addr_o) + ADDR_W'(1)); // R3
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req && !tx_valid && !sp_req && !rx_ready); // R11
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !sp_req && $past(busy) |-> $stable(cnt_o)); // R7
    AST_TX_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_data) && $stable(tx_last)); // R8
    AST_SPACE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        sp_req && sp_ack |=> cnt_o == $past(cnt_o) + CW'(1)); // R10

endmodule

// File: tb/test_tdma_engine.sv
module test_tdma_engine;
    import tdma_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_addr = 1'b0, ld_cnt = 1'b0;
    logic [14:0] ld_data = '0;
    logic [14:0] addr_o;
    logic [15:0] cnt_o;
    logic        cmd_start = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic        busy, done, odd_flag, ovf_flag;
    logic        mem_req, mem_we;
    logic [14:0] mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_ack = 1'b0;
    logic [15:0] mem_rdata = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_last = 1'b0;
    logic        rx_ready;
    logic        tx_valid;
    logic [7:0]  tx_data;
    logic        tx_last;
    logic        tx_ready = 1'b1;
    logic        wres_valid = 1'b0, wres_fail = 1'b0;
    logic        sp_req, sp_dir;
    logic        sp_ack = 1'b0, sp_stop = 1'b0;

    always #5 clk = ~clk;

    tdma_engine i_tdma_engine (
        .clk(clk), .rst_n(rst_n), .ld_addr(ld_addr), .ld_cnt(ld_cnt), .ld_data(ld_data),
        .addr_o(addr_o), .cnt_o(cnt_o), .cmd_start(cmd_start), .cmd_op(cmd_op),
        .busy(busy), .done(done), .odd_flag(odd_flag), .ovf_flag(ovf_flag),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready),
        .wres_valid(wres_valid), .wres_fail(wres_fail),
        .sp_req(sp_req), .sp_dir(sp_dir), .sp_ack(sp_ack), .sp_stop(sp_stop)
    );

    int n_tests = 0;
    int n_fail  = 0;

    typedef struct packed { logic [14:0] a; logic [15:0] d; } wexp_t;
    wexp_t       exp_wr_q[$];
    logic [8:0]  exp_tx_q[$];
    logic [15:0] mem_m [int];
    logic        tx_stall = 1'b0;
    logic        tx_fin = 1'b0;
    int          sp_seen = 0;
    int          sp_stop_at = 0;
    logic        exp_dir = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] bval(input int seed, input int k);
        return 8'(seed + k * 37);
    endfunction

    // Memory responder and write scoreboard
    initial begin
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req) begin
                if (mem_we) begin
                    if (exp_wr_q.size() == 0) chk("R3 unexpected memory write", 1, 0);
                    else begin
                        wexp_t e;
                        e = exp_wr_q.pop_front();
                        chk("R3 write address", 32'(mem_addr), 32'(e.a));
                        chk("R3 write word", 32'(mem_wdata), 32'(e.d));
                    end
                    mem_m[int'(mem_addr)] = mem_wdata;
                end else begin
                    mem_rdata = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 16'h0;
                end
                mem_ack = 1'b1;
            end
        end
    end

    // Byte sink monitor
    initial begin
        forever begin
            @(negedge clk);
            tx_ready = tx_stall ? ~tx_ready : 1'b1;
            if (tx_valid && tx_ready) begin
                if (exp_tx_q.size() == 0) chk("R8 unexpected outgoing byte", 1, 0);
                else chk("R8 outgoing byte", 32'({tx_last, tx_data}), 32'(exp_tx_q.pop_front()));
                if (tx_last) tx_fin = 1'b1;
            end
        end
    end

    // Record spacing agent
    initial begin
        forever begin
            @(negedge clk);
            if (sp_ack) sp_ack = 1'b0;
            else if (sp_req) begin
                sp_seen++;
                chk("R10 spacing direction", 32'(sp_dir), 32'(exp_dir));
                sp_stop = (sp_stop_at != 0) && (sp_seen == sp_stop_at);
                sp_ack  = 1'b1;
            end
        end
    end

    task automatic load_addr(input logic [14:0] v);
        @(negedge clk); ld_addr = 1'b1; ld_data = v;
        @(negedge clk); ld_addr = 1'b0;
    endtask

    task automatic load_cnt(input logic [14:0] v);
        @(negedge clk); ld_cnt = 1'b1; ld_data = v;
        @(negedge clk); ld_cnt = 1'b0;
    endtask

    task automatic start_cmd(input tdma_op_e op);
        @(negedge clk); cmd_op = op; cmd_start = 1'b1;
        @(negedge clk); cmd_start = 1'b0;
    endtask

    task automatic send_bytes(input int seed, input int from, input int upto, input bit mark_last);
        for (int k = from; k < upto; k++) begin
            logic hs;
            rx_valid = 1'b1;
            rx_data  = bval(seed, k);
            rx_last  = mark_last && (k == upto - 1);
            do begin
                hs = rx_ready;
                @(negedge clk);
            end while (!hs);
        end
        rx_valid = 1'b0;
        rx_last  = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    task automatic push_reads(input logic [14:0] a, input int words, input int n, input int seed);
        for (int i = 0; i < words; i++) begin
            wexp_t e;
            e.a = 15'(a + i);
            e.d = {bval(seed, 2*i), (2*i + 1 < n) ? bval(seed, 2*i + 1) : 8'h00};
            exp_wr_q.push_back(e);
        end
    endtask

    task automatic do_read(input string tag, input logic [14:0] a, input logic [14:0] cl,
                           input int n, input int seed);
        logic [15:0] creg;
        int lim, words;
        creg  = {cl[14], cl};
        lim   = 16384 - int'(creg[13:0]);
        words = (n + 1) / 2;
        if (words > lim) words = lim;
        push_reads(a, words, n, seed);
        load_addr(a);
        load_cnt(cl);
        start_cmd(OP_READ);
        send_bytes(seed, 0, n, 1'b1);
        wait_done();
        chk({tag, " R7 count after read"}, 32'(cnt_o), 32'(16'(creg + 16'(words))));
        chk({tag, " R3 address after read"}, 32'(addr_o), 32'(15'(a + 15'(words))));
        chk({tag, " R6 odd flag"}, 32'(odd_flag), 32'(n % 2));
        chk({tag, " R5 overflow flag"}, 32'(ovf_flag), 32'(n > 2 * lim));
        chk({tag, " R4 stored word count"}, 32'(exp_wr_q.size()), 0);
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL R11 watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // Reset state (R11)
        chk("R11 reset busy", 32'(busy), 0);
        chk("R11 reset address", 32'(addr_o), 0);
        chk("R11 reset count", 32'(cnt_o), 0);
        chk("R11 reset mem_req", 32'(mem_req), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 count load bit copy
        load_cnt(15'h4005);
        chk("R1 count load bit14 set", 32'(cnt_o), 32'h0000C005);
        load_cnt(15'h3FFF);
        chk("R1 count load bit14 clear", 32'(cnt_o), 32'h00003FFF);

        // R2 address load
        load_addr(15'h1357);
        chk("R2 address load", 32'(addr_o), 32'h1357);

        // R3 R4 R7 exact-length read: count -4, 8 bytes
        do_read("exact", 15'h0040, 15'h7FFC, 8, 11);
        // R6 odd short read: 5 bytes into 4 words
        do_read("short", 15'h0100, 15'h7FFC, 5, 90);
        // R5 overflow: 7 bytes into 2 words
        do_read("over", 15'h0200, 15'h7FFE, 7, 50);
        // R3 address wrap
        do_read("wrap", 15'h7FFF, 15'h7FFE, 4, 3);
        // R4 zero field requests 16384 words
        do_read("zero", 15'h0300, 15'h0000, 4, 7);

        // R2 R11 loads and starts ignored while busy
        push_reads(15'h0400, 2, 4, 21);
        load_addr(15'h0400);
        load_cnt(15'h7FFE);
        start_cmd(OP_READ);
        send_bytes(21, 0, 1, 1'b0);
        load_addr(15'h1234);
        start_cmd(OP_WRITE);
        send_bytes(21, 1, 4, 1'b1);
        wait_done();
        chk("R2 load during busy ignored", 32'(addr_o), 32'h0402);
        chk("R11 start during busy ignored", 32'(exp_tx_q.size()), 0);
        chk("R7 count after busy read", 32'(cnt_o), 0);

        // R2 load in same cycle as start is dropped
        push_reads(15'h0402, 1, 2, 66);
        load_cnt(15'h7FFF);
        @(negedge clk);
        ld_addr = 1'b1; ld_data = 15'h0ABC; cmd_op = OP_READ; cmd_start = 1'b1;
        @(negedge clk);
        ld_addr = 1'b0; cmd_start = 1'b0;
        send_bytes(66, 0, 2, 1'b1);
        wait_done();
        chk("R2 load with start dropped", 32'(addr_o), 32'h0403);

        // R8 write success with sink stalls
        for (int i = 0; i < 3; i++) begin
            logic [15:0] w;
            w = 16'hA100 + 16'(i * 16'h0111);
            mem_m[32'h0500 + i] = w;
            exp_tx_q.push_back({1'b0, w[15:8]});
            exp_tx_q.push_back({i == 2, w[7:0]});
        end
        load_addr(15'h0500);
        load_cnt(15'h7FFD);
        tx_fin = 1'b0;
        tx_stall = 1'b1;
        start_cmd(OP_WRITE);
        while (!tx_fin) @(negedge clk);
        @(negedge clk);
        wres_valid = 1'b1; wres_fail = 1'b0;
        @(negedge clk);
        wres_valid = 1'b0;
        wait_done();
        tx_stall = 1'b0;
        chk("R8 count cleared after write", 32'(cnt_o), 0);
        chk("R8 address after write", 32'(addr_o), 32'h0503);
        chk("R8 all bytes sent", 32'(exp_tx_q.size()), 0);

        // R9 write failure
        mem_m[32'h0600] = 16'h1122;
        mem_m[32'h0601] = 16'h3344;
        exp_tx_q.push_back(9'h011); exp_tx_q.push_back(9'h022);
        exp_tx_q.push_back(9'h033); exp_tx_q.push_back(9'h144);
        load_addr(15'h0600);
        load_cnt(15'h7FFE);
        tx_fin = 1'b0;
        start_cmd(OP_WRITE);
        while (!tx_fin) @(negedge clk);
        @(negedge clk);
        wres_valid = 1'b1; wres_fail = 1'b1;
        @(negedge clk);
        wres_valid = 1'b0; wres_fail = 1'b0;
        wait_done();
        chk("R9 address rewound", 32'(addr_o), 32'h0600);
        chk("R9 count unchanged", 32'(cnt_o), 32'h0000FFFE);

        // R10 space forward until wrap
        load_addr(15'h0777);
        load_cnt(15'h7FFB);
        sp_seen = 0; sp_stop_at = 0; exp_dir = 1'b0;
        start_cmd(OP_SPACE_FWD);
        wait_done();
        chk("R10 records passed forward", 32'(sp_seen), 5);
        chk("R10 count wrapped", 32'(cnt_o), 0);
        chk("R10 address copy", 32'(addr_o), 0);

        // R10 space reverse stopped by file mark on second record
        load_cnt(15'h7FFB);
        sp_seen = 0; sp_stop_at = 2; exp_dir = 1'b1;
        start_cmd(OP_SPACE_REV);
        wait_done();
        sp_stop = 1'b0;
        chk("R10 records passed reverse", 32'(sp_seen), 2);
        chk("R10 count at stop", 32'(cnt_o), 32'h0000FFFD);
        chk("R10 address copy at stop", 32'(addr_o), 32'h7FFD);

        @(negedge clk);
        chk("R11 idle at end", 32'(busy), 0);
        finish_run();
    end
endmodule